// File: doc/BRIEF.md
# Multiply/Divide High-Low Result Interlock

This block is the timing scoreboard of an integer multiply/divide unit. The unit writes a pair of result registers, called high and low. Each cycle the issue stage presents at most one request. The request names an operation: a 32- or 64-bit multiply or divide, a move into high or low, a move out of high or low, or an instruction that consumes a multiply result, either as an integer operand or as a load/store address. In the same cycle the block answers whether the request must stall. When the request is not stalled it is taken as issued, and the block records the waiting periods that the request imposes on later requests.

The divider is not pipelined, but its busy period begins late. It is idle for the first few cycles after issue and only then occupied. A following divide may therefore issue while the previous one is finishing, as long as the two occupied periods never overlap. A divide writes high and low some cycles after its result latency. Any other writer of high or low waits for that write. A 64-bit multiply makes its low half ready one cycle before its high half, and it blocks a multiply in the cycle directly after it. The block contains no arithmetic. It is a set of down-counters plus a small delay line for the divider's occupied period.

Top module: `hilo_interlock`

## Requirements
- R1: `stall` is a combinational function of the request and the current state. It is never high while `req_valid` is low. A request that is stalled, or that is not valid, changes no timing state.
- R2: Operation codes on `req_op`: 0 multiply-32, 1 multiply-64, 2 divide-32, 3 divide-64, 4 move-to-high, 5 move-to-low, 6 move-from-high, 7 move-from-low, 8 integer use of a multiply result, 9 address use of a multiply result. Codes 10 to 15 never stall and change no timing state.
- R3: A divide issued in cycle t drives `div_busy` from cycle t+4. It stays high for 32 cycles after a 32-bit divide and for 64 cycles after a 64-bit divide. A further divide stalls until cycle t+32 (32-bit) or t+64 (64-bit). Back-to-back occupied periods join without a gap and never overlap.
- R4: After a divide issued in cycle t, move-from-high and move-from-low stall until cycle t+36 (32-bit) or t+68 (64-bit). `hi_ready` and `lo_ready` rise in that same cycle.
- R5: After a divide issued in cycle t, every other writer of high or low (multiplies and moves-to) stalls until cycle t+40 (32-bit) or t+72 (64-bit).
- R6: A 64-bit multiply issued in cycle t stalls any multiply in cycle t+1 only.
- R7: After a multiply issued in cycle t, an integer use stalls until t+3 (32-bit) or t+4 (64-bit). An address use stalls until t+7 for either width.
- R8: After a 32-bit multiply issued in cycle t, both halves are readable from t+3. After a 64-bit multiply, low is readable from t+3 and high from t+4.
- R9: After a move into high or low issued in cycle t, any multiply or divide stalls until t+4. A move out of that same register stalls until t+3.
- R10: After reset no request stalls, `div_busy` is low, and `hi_ready` and `lo_ready` are high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A request is presented this cycle |
| req_op | input | 4 | Operation code of the request (see R2) |
| stall | output | 1 | Request must be held; nothing is recorded |
| div_busy | output | 1 | Divider is in its occupied period |
| hi_ready | output | 1 | A move out of high would not stall |
| lo_ready | output | 1 | A move out of low would not stall |

## Verification
Every internal counter feeds `stall`, so a wrong load value or a missed decrement appears at the port. It shows on the first probe made one cycle before or at the cycle the wait should end, and it moves that boundary by exactly the size of the error. A divider delay line that is shifted by one stage moves the rising or falling edge of `div_busy` by one cycle. A delay line that drops the length bit makes the busy period of a 64-bit divide end 32 cycles early. Both are checked at the edges of the busy period. A stalled request that wrongly loads a counter shows up as an extra stall one cycle after the request, and the bench probes that cycle.

// File: rtl/hilo_pkg.sv
package hilo_pkg;

  typedef enum logic [3:0] {
    OP_MUL32    = 4'd0,
    OP_MUL64    = 4'd1,
    OP_DIV32    = 4'd2,
    OP_DIV64    = 4'd3,
    OP_MTHI     = 4'd4,
    OP_MTLO     = 4'd5,
    OP_MFHI     = 4'd6,
    OP_MFLO     = 4'd7,
    OP_USE_INT  = 4'd8,
    OP_USE_ADDR = 4'd9
  } hl_op_e;

  function automatic logic is_mul(input logic [3:0] op);
    return (op == OP_MUL32) || (op == OP_MUL64);
  endfunction

  function automatic logic is_div(input logic [3:0] op);
    return (op == OP_DIV32) || (op == OP_DIV64);
  endfunction

  function automatic logic is_move_in(input logic [3:0] op);
    return (op == OP_MTHI) || (op == OP_MTLO);
  endfunction

  // A gap of N means a dependent request may go N cycles after the issue
  // cycle, so the counter holds N-1 in the cycle after issue.
  function automatic int unsigned gap_to_count(input int unsigned gap);
    return (gap == 0) ? 0 : gap - 1;
  endfunction

endpackage

// File: rtl/hilo_hold_ctr.sv
module hilo_hold_ctr #(
  parameter int W = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] gap,
  output logic         hold
);
  import hilo_pkg::*;

  logic [W-1:0] cnt;
  logic [W-1:0] dec_val;
  logic [W-1:0] load_val;
  logic [W-1:0] nxt;

  always_comb begin
    dec_val  = (cnt == '0) ? '0 : cnt - W'(1);
    load_val = W'(gap_to_count(int'(gap)));
    // a shorter new wait never cuts an existing one
    nxt      = (load && (load_val > dec_val)) ? load_val : dec_val;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= nxt;
  end

  assign hold = (cnt != '0);

  // R1: without an accepted load the wait only shrinks
  p_grow_only_on_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> (cnt <= $past(cnt)));

endmodule

// File: rtl/hilo_div_window.sv
module hilo_div_window #(
  parameter int LEAD  = 4,
  parameter int LEN_S = 32,
  parameter int LEN_L = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic start_long,
  output logic busy,
  output logic window_open
);
  localparam int STG = LEAD - 1;
  localparam int BW  = $clog2(LEN_L + 1);

  logic [STG-1:0] lead_v;
  logic [STG-1:0] lead_l;
  logic [BW-1:0]  busy_cnt;

  genvar i;
  generate
    for (i = 0; i < STG; i++) begin : g_lead
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) begin
            lead_v[0] <= 1'b0;
            lead_l[0] <= 1'b0;
          end else begin
            lead_v[0] <= start;
            lead_l[0] <= start & start_long;
          end
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rst_n) begin
            lead_v[i] <= 1'b0;
            lead_l[i] <= 1'b0;
          end else begin
            lead_v[i] <= lead_v[i-1];
            lead_l[i] <= lead_l[i-1];
          end
        end
      end
    end
  endgenerate

  assign window_open = lead_v[STG-1];

  always_ff @(posedge clk) begin
    if (!rst_n)
      busy_cnt <= '0;
    else if (window_open)
      busy_cnt <= lead_l[STG-1] ? BW'(LEN_L) : BW'(LEN_S);
    else if (busy_cnt != '0)
      busy_cnt <= busy_cnt - BW'(1);
  end

  assign busy = (busy_cnt != '0);

  // R3: a new occupied period starts only in the last cycle of the old one or later
  p_one_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
    window_open |-> (busy_cnt <= BW'(1)));

endmodule

// File: rtl/hilo_interlock.sv
module hilo_interlock #(
  parameter int DIV32_LAT     = 36,
  parameter int DIV64_LAT     = 68,
  parameter int DIV_LEAD      = 4,
  parameter int HILO_WB_DELAY = 4,
  parameter int MUL32_LAT     = 3,
  parameter int MUL64_HI_LAT  = 4,
  parameter int MUL64_LO_LAT  = 3,
  parameter int MUL64_REISSUE = 2,
  parameter int MT_TO_MULDIV  = 4,
  parameter int MT_TO_MF      = 3,
  parameter int MUL_TO_ADDR   = 7
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  logic [3:0] req_op,
  output logic       stall,
  output logic       div_busy,
  output logic       hi_ready,
  output logic       lo_ready
);
  import hilo_pkg::*;

  localparam int CW       = $clog2(DIV64_LAT + HILO_WB_DELAY + 1);
  localparam int DIV32_GAP = DIV32_LAT - DIV_LEAD;
  localparam int DIV64_GAP = DIV64_LAT - DIV_LEAD;

  // named internal events
  logic accept;
  logic acc_mul32, acc_mul64, acc_div32, acc_div64, acc_mthi, acc_mtlo;
  logic hazard;
  logic hi_h, lo_h, mt_h, blk_h, int_h, addr_h, gate_h, wb_h;
  logic hi_ld, lo_ld, mt_ld, blk_ld, int_ld, addr_ld, gate_ld, wb_ld;
  logic [CW-1:0] hi_gap, lo_gap, mt_gap, blk_gap, int_gap, addr_gap, gate_gap, wb_gap;
  logic window_open;

  always_comb begin
    case (req_op)
      OP_MUL32, OP_MUL64: hazard = blk_h | mt_h | wb_h;
      OP_DIV32, OP_DIV64: hazard = gate_h | mt_h;
      OP_MTHI, OP_MTLO:   hazard = wb_h;
      OP_MFHI:            hazard = hi_h;
      OP_MFLO:            hazard = lo_h;
      OP_USE_INT:         hazard = int_h;
      OP_USE_ADDR:        hazard = addr_h;
      default:            hazard = 1'b0;
    endcase
  end

  assign stall  = req_valid & hazard;
  assign accept = req_valid & ~hazard;

  assign acc_mul32 = accept & (req_op == OP_MUL32);
  assign acc_mul64 = accept & (req_op == OP_MUL64);
  assign acc_div32 = accept & (req_op == OP_DIV32);
  assign acc_div64 = accept & (req_op == OP_DIV64);
  assign acc_mthi  = accept & (req_op == OP_MTHI);
  assign acc_mtlo  = accept & (req_op == OP_MTLO);

  always_comb begin
    hi_ld  = acc_mul32 | acc_mul64 | acc_div32 | acc_div64 | acc_mthi;
    hi_gap = acc_mul32 ? CW'(MUL32_LAT)    :
             acc_mul64 ? CW'(MUL64_HI_LAT) :
             acc_div32 ? CW'(DIV32_LAT)    :
             acc_div64 ? CW'(DIV64_LAT)    : CW'(MT_TO_MF);

    lo_ld  = acc_mul32 | acc_mul64 | acc_div32 | acc_div64 | acc_mtlo;
    lo_gap = acc_mul32 ? CW'(MUL32_LAT)    :
             acc_mul64 ? CW'(MUL64_LO_LAT) :
             acc_div32 ? CW'(DIV32_LAT)    :
             acc_div64 ? CW'(DIV64_LAT)    : CW'(MT_TO_MF);

    mt_ld    = acc_mthi | acc_mtlo;
    mt_gap   = CW'(MT_TO_MULDIV);

    blk_ld   = acc_mul64;
    blk_gap  = CW'(MUL64_REISSUE);

    int_ld   = acc_mul32 | acc_mul64;
    int_gap  = acc_mul64 ? CW'(MUL64_HI_LAT) : CW'(MUL32_LAT);

    addr_ld  = acc_mul32 | acc_mul64;
    addr_gap = CW'(MUL_TO_ADDR);

    gate_ld  = acc_div32 | acc_div64;
    gate_gap = acc_div64 ? CW'(DIV64_GAP) : CW'(DIV32_GAP);

    wb_ld    = acc_div32 | acc_div64;
    wb_gap   = acc_div64 ? CW'(DIV64_LAT + HILO_WB_DELAY) : CW'(DIV32_LAT + HILO_WB_DELAY);
  end

  hilo_hold_ctr #(.W(CW)) u_hi   (.clk(clk), .rst_n(rst_n), .load(hi_ld),   .gap(hi_gap),   .hold(hi_h));
  hilo_hold_ctr #(.W(CW)) u_lo   (.clk(clk), .rst_n(rst_n), .load(lo_ld),   .gap(lo_gap),   .hold(lo_h));
  hilo_hold_ctr #(.W(CW)) u_mt   (.clk(clk), .rst_n(rst_n), .load(mt_ld),   .gap(mt_gap),   .hold(mt_h));
  hilo_hold_ctr #(.W(CW)) u_blk  (.clk(clk), .rst_n(rst_n), .load(blk_ld),  .gap(blk_gap),  .hold(blk_h));
  hilo_hold_ctr #(.W(CW)) u_int  (.clk(clk), .rst_n(rst_n), .load(int_ld),  .gap(int_gap),  .hold(int_h));
  hilo_hold_ctr #(.W(CW)) u_addr (.clk(clk), .rst_n(rst_n), .load(addr_ld), .gap(addr_gap), .hold(addr_h));
  hilo_hold_ctr #(.W(CW)) u_gate (.clk(clk), .rst_n(rst_n), .load(gate_ld), .gap(gate_gap), .hold(gate_h));
  hilo_hold_ctr #(.W(CW)) u_wb   (.clk(clk), .rst_n(rst_n), .load(wb_ld),   .gap(wb_gap),   .hold(wb_h));

  hilo_div_window #(
    .LEAD (DIV_LEAD),
    .LEN_S(DIV32_GAP),
    .LEN_L(DIV64_GAP)
  ) u_win (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (acc_div32 | acc_div64),
    .start_long (acc_div64),
    .busy       (div_busy),
    .window_open(window_open)
  );

  assign hi_ready = ~hi_h;
  assign lo_ready = ~lo_h;

  // R1: no stall without a request
  p_stall_needs_valid_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> !stall);

  // R6: the cycle after a wide multiply takes no multiply
  p_mul64_blocks_next_r6: assert property (@(posedge clk) disable iff (!rst_n)
    acc_mul64 |=> !(req_valid && is_mul(req_op) && !stall));

  // R4: a divide hides both halves in the next cycle
  p_div_hides_result_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && is_div(req_op)) |=> (!hi_ready && !lo_ready));

  // R5: writers of high/low are held while the divider is occupied
  p_no_write_in_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (div_busy && req_valid && (is_mul(req_op) || is_move_in(req_op))) |-> stall);

  // R3: the occupied period opens only after a divide was taken
  p_window_after_issue_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(div_busy) |-> $past(window_open));

endmodule

// File: tb/sim_hilo_interlock.sv
module sim_hilo_interlock;
  import hilo_pkg::*;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic [3:0] req_op = 4'd0;
  logic       stall, div_busy, hi_ready, lo_ready;

  hilo_interlock u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .stall(stall), .div_busy(div_busy), .hi_ready(hi_ready), .lo_ready(lo_ready)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    int    kind;   // 0 stall, 1 div_busy, 2 hi_ready, 3 lo_ready
    bit    exp;
    string tag;
  } exp_t;

  exp_t q[$];
  int   checks = 0;
  int   errors = 0;
  int   slot = 0;
  int   base = 0;
  bit   done = 1'b0;

  // monitor: compares expectations pushed in this cycle, away from the edge
  always @(negedge clk) begin
    #2;
    while (q.size() > 0) begin
      exp_t e;
      logic act;
      e = q.pop_front();
      case (e.kind)
        0: act = stall;
        1: act = div_busy;
        2: act = hi_ready;
        default: act = lo_ready;
      endcase
      checks++;
      if (act !== e.exp) begin
        errors++;
        $display("FAIL %s: got %0b expected %0b", e.tag, act, e.exp);
      end
    end
  end

  task automatic tick(input bit v, input logic [3:0] op);
    @(negedge clk);
    req_valid = v;
    req_op    = op;
    slot++;
  endtask

  task automatic start(input logic [3:0] op);
    tick(1'b1, op);
    base = slot;
  endtask

  task automatic at(input int k, input bit v, input logic [3:0] op);
    while (slot + 1 < base + k) tick(1'b0, 4'd0);
    tick(v, op);
  endtask

  task automatic expect_bit(input int kind, input bit val, input string tag);
    exp_t e;
    e.kind = kind; e.exp = val; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic settle();
    repeat (100) tick(1'b0, 4'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got hung expected finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R10 reset state
    tick(1'b0, 4'd0);
    expect_bit(0, 1'b0, "R10 stall idle");
    expect_bit(1, 1'b0, "R10 div_busy");
    expect_bit(2, 1'b1, "R10 hi_ready");
    expect_bit(3, 1'b1, "R10 lo_ready");
    tick(1'b1, 4'd6);
    expect_bit(0, 1'b0, "R10 move-from-high after reset");

    // R3 divider windows, R1 invalid request
    start(4'd2);
    at(1, 1'b1, 4'd6);   expect_bit(0, 1'b1, "R4 mfhi after div32"); expect_bit(1, 1'b0, "R3 busy t+1");
    at(3, 1'b0, 4'd0);   expect_bit(1, 1'b0, "R3 busy t+3");
    at(4, 1'b0, 4'd0);   expect_bit(1, 1'b1, "R3 busy t+4");
    at(31, 1'b1, 4'd3);  expect_bit(0, 1'b1, "R3 div64 at t+31");
    at(32, 1'b1, 4'd3);  expect_bit(0, 1'b0, "R3 div64 at t+32");
    at(35, 1'b0, 4'd0);  expect_bit(1, 1'b1, "R3 busy t+35");
    at(36, 1'b0, 4'd0);  expect_bit(1, 1'b1, "R3 busy joins t+36");
    at(40, 1'b0, 4'd2);  expect_bit(0, 1'b0, "R1 invalid divide");
    at(41, 1'b1, 4'd12); expect_bit(0, 1'b0, "R2 unused code");
    at(99, 1'b0, 4'd0);  expect_bit(1, 1'b1, "R3 busy end of long");
    at(100, 1'b0, 4'd0); expect_bit(1, 1'b0, "R3 busy after long");
    settle();

    // R4, R5 divide result and write-back
    start(4'd3);
    at(67, 1'b1, 4'd7);  expect_bit(0, 1'b1, "R4 mflo t+67");
    at(68, 1'b1, 4'd7);  expect_bit(0, 1'b0, "R4 mflo t+68");
                         expect_bit(2, 1'b1, "R4 hi_ready t+68");
    at(70, 1'b1, 4'd5);  expect_bit(0, 1'b1, "R5 mtlo t+70");
    at(71, 1'b1, 4'd0);  expect_bit(0, 1'b1, "R5 mul32 t+71");
    at(72, 1'b1, 4'd5);  expect_bit(0, 1'b0, "R5 mtlo t+72");
    settle();

    // R6 and R1: stalled wide multiply leaves no block
    start(4'd1);
    at(1, 1'b1, 4'd1);   expect_bit(0, 1'b1, "R6 mul64 t+1");
    at(2, 1'b1, 4'd0);   expect_bit(0, 1'b0, "R6 R1 mul32 t+2");
    settle();

    // R7, R8 wide multiply
    start(4'd1);
    at(2, 1'b0, 4'd0);   expect_bit(3, 1'b0, "R8 lo t+2");
    at(3, 1'b1, 4'd8);   expect_bit(0, 1'b1, "R7 int use t+3");
                         expect_bit(3, 1'b1, "R8 lo t+3");
                         expect_bit(2, 1'b0, "R8 hi t+3");
    at(4, 1'b1, 4'd8);   expect_bit(0, 1'b0, "R7 int use t+4");
                         expect_bit(2, 1'b1, "R8 hi t+4");
    at(6, 1'b1, 4'd9);   expect_bit(0, 1'b1, "R7 addr use t+6");
    at(7, 1'b1, 4'd9);   expect_bit(0, 1'b0, "R7 addr use t+7");
    settle();

    // R7, R8 narrow multiply
    start(4'd0);
    at(2, 1'b1, 4'd8);   expect_bit(0, 1'b1, "R7 int use t+2");
                         expect_bit(2, 1'b0, "R8 hi t+2");
    at(3, 1'b1, 4'd8);   expect_bit(0, 1'b0, "R7 int use t+3");
                         expect_bit(2, 1'b1, "R8 hi t+3");
                         expect_bit(3, 1'b1, "R8 lo t+3");
    at(6, 1'b1, 4'd9);   expect_bit(0, 1'b1, "R7 addr t+6");
    at(7, 1'b1, 4'd9);   expect_bit(0, 1'b0, "R7 addr t+7");
    settle();

    // R9 move to high
    start(4'd4);
    at(1, 1'b1, 4'd6);   expect_bit(0, 1'b1, "R9 mfhi t+1");
    at(2, 1'b0, 4'd0);   expect_bit(3, 1'b1, "R9 lo untouched");
                         expect_bit(2, 1'b0, "R9 hi t+2");
    at(3, 1'b1, 4'd2);   expect_bit(0, 1'b1, "R9 div t+3");
                         expect_bit(2, 1'b1, "R9 hi t+3");
    at(4, 1'b1, 4'd2);   expect_bit(0, 1'b0, "R9 div t+4");
    settle();

    // R9 move to low
    start(4'd5);
    at(2, 1'b1, 4'd7);   expect_bit(0, 1'b1, "R9 mflo t+2");
    at(3, 1'b1, 4'd1);   expect_bit(0, 1'b1, "R9 mul64 t+3");
                         expect_bit(3, 1'b1, "R9 lo t+3");
    at(4, 1'b1, 4'd1);   expect_bit(0, 1'b0, "R9 mul64 t+4");
    settle();

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule